// File: doc/BRIEF.md
# Debug Breakpoint Status Evaluator

This block decides, once per evaluation request, which of four hardware debug slots have been hit and whether a debug exception must be raised. A slot of the execution kind compares its address register with the current instruction pointer. A slot of either data kind takes a one-bit hit flag, which comes from a watch unit elsewhere on the memory path. A slot of the I/O kind is never considered hit.

The debug status register holds the result. Its low four bits show every slot that matched, whether or not that slot is enabled. Every other bit keeps its old value. The register is only written when at least one matching slot is enabled, or when the caller forces an update. The exception pulse is raised only when a matching slot is enabled. The pipeline asserts `eval_i` for one cycle at each instruction boundary it wants checked.

Top module: `dbg_bp_eval`

## Requirements
- R1: The kind of slot i sits in `ctrl_i[17+4i:16+4i]`, where 00 means execution, 01 means data write, 10 means I/O and 11 means data read-or-write. An execution slot matches when its address equals `ip_i`, and it ignores `data_hit_i`.
- R2: A data-write slot (01) or a data read-or-write slot (11) matches exactly when its `data_hit_i` bit is 1. Its address and `ip_i` have no effect.
- R3: An I/O slot (10) never matches, whatever its address, the instruction pointer or its hit flag.
- R4: On a commit, bits [3:0] of `stat_o` become the match vector, with bit i set for slot i, and bits [31:4] keep their previous value. After reset, `stat_o` is 32'hFFFF0FF0.
- R5: Slot i is enabled when `ctrl_i[2i]` or `ctrl_i[2i+1]` is 1. One cycle after an evaluation, `exc_o` is 1 for exactly one cycle if some matching slot is enabled, and it stays 0 otherwise.
- R6: An evaluation commits the status only if a matching slot is enabled or `force_upd_i` is 1. Otherwise `stat_o` is unchanged, including when only disabled slots match.
- R7: When `eval_i` is 0, `stat_o` stays unchanged and `exc_o` is 0, whatever `force_upd_i` and the other inputs are.
- R8: The length fields `ctrl_i[19+4i:18+4i]` and `ctrl_i[15:8]` do not affect matching, the status or the exception.
- R9: While `rst_n` is low at a clock edge, `stat_o` returns to 32'hFFFF0FF0 and `exc_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| eval_i | input | 1 | Evaluate the slots this cycle |
| force_upd_i | input | 1 | Commit the status even with no enabled hit |
| ip_i | input | 32 | Current instruction pointer |
| slot_addr_i | input | 128 | Four slot addresses, slot i in bits [32i+31:32i] |
| ctrl_i | input | 32 | Debug control word: enables, kinds, lengths |
| data_hit_i | input | 4 | Per-slot data watch hit flags |
| stat_o | output | 32 | Debug status register |
| exc_o | output | 1 | Debug exception request, one-cycle pulse |

## Verification
The status register and the exception pulse both come from one register stage. The result of an evaluation sampled at a rising edge appears on the outputs right after that edge and holds until the next edge. The bench drives every input on the falling edge and compares both outputs on the following falling edge, half a period after the edge that produced them. It keeps its own model of the status register and updates it with the same one-edge latency. Idle cycles, forced updates and reset are checked with the same falling-edge timing.

// File: rtl/dbg_bp_pkg.sv
// Package: shared slot-kind encoding and control-word field helpers for the
// debug breakpoint evaluator. Assumes at most four slots, so that the enable
// pairs fit in the low byte of the control word.
package dbg_bp_pkg;

    typedef enum logic [1:0] {
        BP_EXEC  = 2'b00,
        BP_WRITE = 2'b01,
        BP_IO    = 2'b10,
        BP_RDWR  = 2'b11
    } bp_kind_e;

    localparam int KIND_BASE = 16;  // first kind field bit
    localparam int SLOT_STEP = 4;   // bits per slot in the upper half

    // Extracts the kind field of one slot.
    function automatic bp_kind_e kind_of(input logic [31:0] ctrl, input int slot);
        return bp_kind_e'(ctrl[KIND_BASE + SLOT_STEP*slot +: 2]);
    endfunction

    // Local or global enable of one slot.
    function automatic logic enabled_of(input logic [31:0] ctrl, input int slot);
        return ctrl[2*slot] | ctrl[2*slot + 1];
    endfunction

endpackage

// File: rtl/dbg_slot_match.sv
// Module: combinational match test for one breakpoint slot.
// Assumes: the data hit flag is already qualified by the watch unit and is
// only meaningful for data kinds.
module dbg_slot_match
    import dbg_bp_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  bp_kind_e          kind_i,
    input  logic [ADDR_W-1:0] slot_addr_i,
    input  logic [ADDR_W-1:0] ip_i,
    input  logic              data_hit_i,
    output logic              hit_o
);

    // Selects the match source from the slot kind.
    always_comb begin
        unique case (kind_i)
            BP_EXEC:          hit_o = (slot_addr_i == ip_i);
            BP_WRITE, BP_RDWR: hit_o = data_hit_i;
            default:          hit_o = 1'b0;
        endcase
    end

    // An I/O slot never reports a hit.
    always_comb begin
        AST_IO_NEVER: assert (kind_i != BP_IO || !hit_o); // R3
    end

endmodule

// File: rtl/dbg_status_merge.sv
// Module: merges slot hits into the debug status register and raises the
// exception pulse. Assumes: hit_i and en_i are stable in the evaluate cycle.
module dbg_status_merge #(
    parameter int          NUM_SLOTS = 4,
    parameter int          STAT_W    = 32,
    parameter logic [31:0] STAT_RST  = 32'hFFFF0FF0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 eval_i,
    input  logic                 force_i,
    input  logic [NUM_SLOTS-1:0] hit_i,
    input  logic [NUM_SLOTS-1:0] en_i,
    output logic [STAT_W-1:0]    stat_o,
    output logic                 exc_o
);

    localparam logic [STAT_W-1:0] RST_VAL = STAT_RST[STAT_W-1:0];

    logic              live_hit;
    logic              commit;
    logic [STAT_W-1:0] stat_next;

    // Decides whether this evaluation commits and whether it traps.
    always_comb begin
        live_hit  = |(hit_i & en_i);
        commit    = eval_i && (live_hit || force_i);
        stat_next = {stat_o[STAT_W-1:NUM_SLOTS], hit_i};
    end

    // Status register and the single-cycle exception flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_o <= RST_VAL;
            exc_o  <= 1'b0;
        end else begin
            if (commit) stat_o <= stat_next;
            exc_o <= eval_i && live_hit;
        end
    end

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !eval_i |=> ($stable(stat_o) && !exc_o)); // R7
    AST_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_i && !force_i && ((hit_i & en_i) == '0)) |=> $stable(stat_o)); // R6
    AST_EXC_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_i && ((hit_i & en_i) != '0)) |=> exc_o); // R5
    AST_EXC_HAS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        exc_o |-> (stat_o[NUM_SLOTS-1:0] != '0)); // R5
    AST_UPPER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        eval_i |=> $stable(stat_o[STAT_W-1:NUM_SLOTS])); // R4

endmodule

// File: rtl/dbg_bp_eval.sv
// Module: top of the debug breakpoint evaluator. It decodes the control word,
// runs one matcher per slot and feeds the status merge.
// Assumes: the control word layout gives an enable pair per slot in the low
// byte and a kind/length nibble per slot from bit 16 upward.
module dbg_bp_eval
    import dbg_bp_pkg::*;
#(
    parameter int          NUM_SLOTS = 4,
    parameter int          ADDR_W    = 32,
    parameter int          STAT_W    = 32,
    parameter logic [31:0] STAT_RST  = 32'hFFFF0FF0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        eval_i,
    input  logic                        force_upd_i,
    input  logic [ADDR_W-1:0]           ip_i,
    input  logic [NUM_SLOTS*ADDR_W-1:0] slot_addr_i,
    input  logic [31:0]                 ctrl_i,
    input  logic [NUM_SLOTS-1:0]        data_hit_i,
    output logic [STAT_W-1:0]           stat_o,
    output logic                        exc_o
);

    localparam int MAX_SLOTS = (32 - KIND_BASE) / SLOT_STEP;

    logic [NUM_SLOTS-1:0] slot_hit;
    logic [NUM_SLOTS-1:0] slot_en;

    initial begin
        AST_SLOT_FIT: assert (NUM_SLOTS <= MAX_SLOTS && NUM_SLOTS < STAT_W); // R1
    end

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        bp_kind_e kind;

        // Decodes this slot's kind and enable from the control word.
        always_comb begin
            kind        = kind_of(ctrl_i, s);
            slot_en[s]  = enabled_of(ctrl_i, s);
        end

        dbg_slot_match #(.ADDR_W(ADDR_W)) u_match (
            .kind_i      (kind),
            .slot_addr_i (slot_addr_i[s*ADDR_W +: ADDR_W]),
            .ip_i        (ip_i),
            .data_hit_i  (data_hit_i[s]),
            .hit_o       (slot_hit[s])
        );
    end

    dbg_status_merge #(
        .NUM_SLOTS (NUM_SLOTS),
        .STAT_W    (STAT_W),
        .STAT_RST  (STAT_RST)
    ) u_merge (
        .clk     (clk),
        .rst_n   (rst_n),
        .eval_i  (eval_i),
        .force_i (force_upd_i),
        .hit_i   (slot_hit),
        .en_i    (slot_en),
        .stat_o  (stat_o),
        .exc_o   (exc_o)
    );

endmodule

// File: tb/dbg_bp_eval_tb.sv
`timescale 1ns/1ps
module dbg_bp_eval_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         eval_i = 1'b0;
    logic         force_upd_i = 1'b0;
    logic [31:0]  ip_i = '0;
    logic [127:0] slot_addr_i = '0;
    logic [31:0]  ctrl_i = '0;
    logic [3:0]   data_hit_i = '0;
    logic [31:0]  stat_o;
    logic         exc_o;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_stat = 32'hFFFF0FF0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    dbg_bp_eval u_dut (
        .clk(clk), .rst_n(rst_n), .eval_i(eval_i), .force_upd_i(force_upd_i),
        .ip_i(ip_i), .slot_addr_i(slot_addr_i), .ctrl_i(ctrl_i),
        .data_hit_i(data_hit_i), .stat_o(stat_o), .exc_o(exc_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Builds a control word: kinds, enables (local or global bit), lengths.
    function automatic logic [31:0] mk_ctrl(input logic [7:0] kinds, input logic [3:0] en,
                                            input bit glob, input logic [7:0] lens);
        logic [31:0] c = '0;
        for (int i = 0; i < 4; i++) begin
            c[2*i + (glob ? 1 : 0)] = en[i];
            c[16+4*i +: 2] = kinds[2*i +: 2];
            c[18+4*i +: 2] = lens[2*i +: 2];
        end
        return c;
    endfunction

    // One evaluation: drive at a falling edge, check at the next falling edge.
    task automatic run_eval(input logic [7:0] kinds, input logic [3:0] en, input bit glob,
                            input logic [7:0] lens, input logic [3:0] ipm,
                            input logic [3:0] hits, input bit frc, input logic [31:0] ip,
                            input string req);
        logic [3:0] m;
        bit trap;
        for (int i = 0; i < 4; i++) begin
            slot_addr_i[32*i +: 32] = ipm[i] ? ip : (ip ^ (32'h1 << (7*i)));
            case (kinds[2*i +: 2])
                2'b00: m[i] = ipm[i];
                2'b10: m[i] = 1'b0;
                default: m[i] = hits[i];
            endcase
        end
        ctrl_i = mk_ctrl(kinds, en, glob, lens);
        ip_i = ip; data_hit_i = hits; force_upd_i = frc; eval_i = 1'b1;
        trap = |(m & en);
        if (trap || frc) exp_stat = {exp_stat[31:4], m};
        @(negedge clk);
        check({req, " status"}, stat_o, exp_stat);
        check({req, " exception"}, {31'b0, exc_o}, {31'b0, trap});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R9 reset status", stat_o, 32'hFFFF0FF0);
        check("R9 reset exception", {31'b0, exc_o}, 32'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 execution slot 0 enabled, matches the pointer
        run_eval(8'h00, 4'b0001, 0, 8'h00, 4'b0001, 4'b0000, 0, 32'h1000, "R1");
        // R2 write slot 1 via hit flag, pointer mismatch ignored
        run_eval(8'b0000_0100, 4'b0010, 0, 8'h00, 4'b0000, 4'b0010, 0, 32'h2000, "R2");
        // R3 I/O slot with everything matching: no hit, no commit
        run_eval(8'b1010_1010, 4'b1111, 0, 8'h00, 4'b1111, 4'b1111, 0, 32'h3000, "R3");
        // R6 disabled-only match: no commit, then forced commit of that match
        run_eval(8'h00, 4'b0000, 0, 8'h00, 4'b0110, 4'b0000, 0, 32'h4000, "R6 disabled");
        run_eval(8'h00, 4'b0000, 0, 8'h00, 4'b0110, 4'b0000, 1, 32'h4000, "R6 forced");
        // R5 global enable bit alone enables slot 3
        run_eval(8'hC0, 4'b1000, 1, 8'h00, 4'b0000, 4'b1000, 0, 32'h5000, "R5 global");
        // R8 length fields all ones give the same outcome
        run_eval(8'h00, 4'b0001, 0, 8'hFF, 4'b0101, 4'b0000, 0, 32'h6000, "R8 length");

        // R7 idle cycle with force and an enabled match present
        eval_i = 1'b0; force_upd_i = 1'b1; ctrl_i = mk_ctrl(8'h00, 4'hF, 0, 8'h00);
        for (int i = 0; i < 4; i++) slot_addr_i[32*i +: 32] = ip_i;
        @(negedge clk);
        check("R7 idle status", stat_o, exp_stat);
        check("R7 idle exception", {31'b0, exc_o}, 32'b0);

        // Sweep of all kind combinations against all enable patterns (R1 R2 R3 R4 R5 R6)
        for (int t = 0; t < 256; t++) begin
            for (int e = 0; e < 16; e++) begin
                run_eval(t[7:0], e[3:0], t[0], t[7:0] ^ 8'h5A, 4'((t + 3*e) & 15),
                         4'(t[3:0] ^ e[3:0]), bit'((t ^ e) & 1),
                         32'h0040_0000 + 32'(t*64 + e*4), "R4 sweep");
            end
        end

        eval_i = 1'b0; force_upd_i = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 reset again", stat_o, 32'hFFFF0FF0);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule